// File: doc/BRIEF.md
# PCI Address Window Translator

This block turns an address seen on the PCI side, together with the length of the transfer, into a host physical address. It holds a small, parameterised set of programmable windows. Each window has a flags word whose two-bit space code marks it as I/O, plain memory or prefetchable memory. Each window also has a PCI-side base, a physical base, a 64-bit size and an enable bit.

A request names its address, its length and whether it is an I/O or a memory access. The windows are searched from index 0 upward. The first enabled window that accepts the request's space and fully contains the byte range gives the translation. When no window qualifies, the block reports a miss. Windows are loaded one field at a time through a write port. The result is registered and appears one cycle after the request strobe.

Top module: `xlat_window_translator`

## Requirements
- R1: After reset, rsp_valid, rsp_hit, rsp_addr and rsp_win are zero and every window is disabled, so any request misses.
- R2: A write with wr_en high updates the field of window wr_idx that wr_sel chooses. The codes are 0 flags (wr_data[31:0]), 1 PCI base, 2 physical base, 3 size and 4 enable (wr_data[0]). The codes 5 to 7 change nothing.
- R3: An I/O request (req_is_mem=0) can match only a window whose flags bits 25:24 equal 2'b01.
- R4: A memory request (req_is_mem=1) can match any window whose flags bit 25 is 1, which covers code 2'b10 (memory) and code 2'b11 (prefetchable).
- R5: A window contains a request when req_addr >= PCI base and req_addr + req_size <= PCI base + window size. Both sums are taken at 65 bits, so they never wrap.
- R6: On a hit, rsp_addr = req_addr - PCI base + physical base, modulo 2^64.
- R7: When several windows qualify, the lowest index wins, and rsp_win reports that index.
- R8: On a miss, rsp_hit is 0 and rsp_addr and rsp_win are 0.
- R9: rsp_valid is high in exactly the cycle after each cycle with req_valid high. Back-to-back requests give back-to-back results, and the response fields hold while no request is made.
- R10: A window whose enable bit is 0 never matches, whatever its other fields hold.
- R11: A request made in the same cycle as a window write is translated with the window contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Window field write strobe |
| wr_idx | input | IDX_W | Window index to write |
| wr_sel | input | 3 | Field select (0 flags, 1 PCI base, 2 physical base, 3 size, 4 enable) |
| wr_data | input | 64 | Write data |
| req_valid | input | 1 | Translation request strobe |
| req_is_mem | input | 1 | 1 for a memory request, 0 for an I/O request |
| req_addr | input | 64 | PCI-side request address |
| req_size | input | 64 | Request length in bytes |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_hit | output | 1 | 1 when a window matched |
| rsp_addr | output | 64 | Translated physical address, 0 on miss |
| rsp_win | output | IDX_W | Index of the matching window, 0 on miss |

## Verification
Every translation result is due exactly one clock after its request strobe. A window write takes effect at the first edge after it is driven. The bench drives inputs on falling edges and pushes the expected result into a queue at the moment it drives the request. A monitor on the next falling edge pops that item and compares it with the outputs. In every cycle the monitor also checks that rsp_valid equals the strobe captured at the previous rising edge. For the same-cycle write case, the expected value is computed from the window state before the model applies the write.

// File: rtl/xlat_win_pkg.sv
package xlat_win_pkg;

    localparam int ADDR_W  = 64;
    localparam int FLAGS_W = 32;
    localparam int SEL_W   = 3;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [FLAGS_W-1:0] flags_t;
    typedef logic [ADDR_W:0]    wide_t;

    typedef enum logic [SEL_W-1:0] {
        FLD_FLAGS     = 3'd0,
        FLD_PCI_BASE  = 3'd1,
        FLD_PHYS_BASE = 3'd2,
        FLD_SIZE      = 3'd3,
        FLD_ENABLE    = 3'd4
    } fld_e;

    localparam logic [1:0] SPACE_IO = 2'b01;
    localparam int SPACE_HI = 25;
    localparam int SPACE_LO = 24;

    typedef struct packed {
        logic   en;
        flags_t flags;
        addr_t  pci_base;
        addr_t  phys_base;
        addr_t  size;
    } win_t;

    typedef struct packed {
        logic  is_mem;
        addr_t addr;
        addr_t size;
    } req_t;

    function automatic logic space_ok(input flags_t f, input logic is_mem);
        if (is_mem)
            return f[SPACE_HI];
        return f[SPACE_HI:SPACE_LO] == SPACE_IO;
    endfunction

    function automatic logic range_ok(input win_t w, input req_t r);
        wide_t r_end;
        wide_t w_end;
        r_end = {1'b0, r.addr} + {1'b0, r.size};
        w_end = {1'b0, w.pci_base} + {1'b0, w.size};
        return (r.addr >= w.pci_base) && (r_end <= w_end);
    endfunction

    function automatic addr_t translate(input win_t w, input addr_t a);
        return a - w.pci_base + w.phys_base;
    endfunction

endpackage

// File: rtl/xlat_win_bank.sv
module xlat_win_bank
    import xlat_win_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEL_W-1:0] wr_sel,
    input  addr_t            wr_data,
    output win_t             wins [NUM_WIN]
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        win_t w_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                case (wr_sel)
                    FLD_FLAGS:     w_q.flags     <= wr_data[FLAGS_W-1:0];
                    FLD_PCI_BASE:  w_q.pci_base  <= wr_data;
                    FLD_PHYS_BASE: w_q.phys_base <= wr_data;
                    FLD_SIZE:      w_q.size      <= wr_data;
                    FLD_ENABLE:    w_q.en        <= wr_data[0];
                    default:       ;
                endcase
            end
        end

        assign wins[i] = w_q;
    end

endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
    import xlat_win_pkg::*;
(
    input  win_t  win,
    input  req_t  req,
    output logic  hit,
    output addr_t xaddr
);

    logic sp_hit;
    logic rg_hit;

    always_comb begin
        sp_hit = space_ok(win.flags, req.is_mem);
        rg_hit = range_ok(win, req);
        hit    = win.en && sp_hit && rg_hit;
        xaddr  = translate(win, req.addr);
    end

endmodule

// File: rtl/xlat_win_pick.sv
module xlat_win_pick
    import xlat_win_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hits,
    input  addr_t              xaddrs [NUM_WIN],
    output logic               any_hit,
    output logic [IDX_W-1:0]   sel_idx,
    output addr_t              sel_addr
);

    always_comb begin
        any_hit  = 1'b0;
        sel_idx  = '0;
        sel_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_addr = xaddrs[i];
            end
        end
    end

endmodule

// File: rtl/xlat_window_translator.sv
module xlat_window_translator
    import xlat_win_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_sel,
    input  logic [63:0]      wr_data,
    input  logic             req_valid,
    input  logic             req_is_mem,
    input  logic [63:0]      req_addr,
    input  logic [63:0]      req_size,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [63:0]      rsp_addr,
    output logic [IDX_W-1:0] rsp_win
);

    win_t               wins   [NUM_WIN];
    addr_t              xaddrs [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    req_t               req;
    logic               any_hit;
    logic [IDX_W-1:0]   pick_idx;
    addr_t              pick_addr;

    assign req = '{is_mem: req_is_mem, addr: req_addr, size: req_size};

    xlat_win_bank #(.NUM_WIN(NUM_WIN)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wins    (wins)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        xlat_win_match u_match (
            .win   (wins[i]),
            .req   (req),
            .hit   (win_hit[i]),
            .xaddr (xaddrs[i])
        );
    end

    xlat_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hits     (win_hit),
        .xaddrs   (xaddrs),
        .any_hit  (any_hit),
        .sel_idx  (pick_idx),
        .sel_addr (pick_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_win   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit  <= any_hit;
                rsp_addr <= any_hit ? pick_addr : '0;
                rsp_win  <= any_hit ? pick_idx : '0;
            end
        end
    end

endmodule

// File: rtl/xlat_window_checker.sv
module xlat_window_checker #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [63:0]        rsp_addr,
    input logic [IDX_W-1:0]   rsp_win,
    input logic [NUM_WIN-1:0] match_vec
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !rsp_valid && !rsp_hit);

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_hit) && $stable(rsp_addr) && $stable(rsp_win));

    assert_miss_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == 64'd0 && rsp_win == '0));

    assert_hit_when_match_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && match_vec != '0) |=> rsp_hit);

    assert_miss_when_none_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && match_vec == '0) |=> !rsp_hit);

    assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && match_vec[0]) |=> rsp_win == '0);

endmodule

bind xlat_window_translator xlat_window_checker #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr),
    .rsp_win   (rsp_win),
    .match_vec (win_hit)
);

// File: tb/xlat_window_translator_bench.sv
module xlat_window_translator_bench;

    localparam int NW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [2:0]    wr_sel = '0;
    logic [63:0]   wr_data = '0;
    logic          req_valid = 1'b0;
    logic          req_is_mem = 1'b0;
    logic [63:0]   req_addr = '0;
    logic [63:0]   req_size = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [63:0]   rsp_addr;
    logic [IW-1:0] rsp_win;

    always #4 clk = ~clk;

    xlat_window_translator #(.NUM_WIN(NW)) u_xlat_window_translator (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_is_mem(req_is_mem),
        .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_win(rsp_win)
    );

    typedef struct {
        logic          hit;
        logic [63:0]   addr;
        logic [IW-1:0] win;
        string         tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic        req_seen = 1'b0;

    logic [31:0] m_flags [NW];
    logic [63:0] m_pci   [NW];
    logic [63:0] m_phys  [NW];
    logic [63:0] m_size  [NW];
    logic        m_en    [NW];

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic is_mem, input logic [63:0] a,
                                   input logic [63:0] s, input string tag);
        exp_t e;
        e.hit = 1'b0; e.addr = '0; e.win = '0; e.tag = tag;
        for (int i = 0; i < NW; i++) begin
            logic sp;
            logic [64:0] re;
            logic [64:0] we;
            sp = is_mem ? m_flags[i][25] : (m_flags[i][25:24] == 2'b01);
            re = {1'b0, a} + {1'b0, s};
            we = {1'b0, m_pci[i]} + {1'b0, m_size[i]};
            if (!e.hit && m_en[i] && sp && a >= m_pci[i] && re <= we) begin
                e.hit  = 1'b1;
                e.addr = a - m_pci[i] + m_phys[i];
                e.win  = IW'(i);
            end
        end
        return e;
    endfunction

    task automatic apply_model_write(input int idx, input int sel, input logic [63:0] d);
        case (sel)
            0: m_flags[idx] = d[31:0];
            1: m_pci[idx]   = d;
            2: m_phys[idx]  = d;
            3: m_size[idx]  = d;
            4: m_en[idx]    = d[0];
            default: ;
        endcase
    endtask

    task automatic wr(input int idx, input int sel, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = 3'(sel); wr_data = d;
        apply_model_write(idx, sel, d);
    endtask

    task automatic rq(input logic is_mem, input logic [63:0] a, input logic [63:0] s,
                      input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b1; req_is_mem = is_mem; req_addr = a; req_size = s;
        sb_q.push_back(model(is_mem, a, s, tag));
    endtask

    task automatic rq_with_wr(input logic is_mem, input logic [63:0] a, input logic [63:0] s,
                              input int idx, input int sel, input logic [63:0] d,
                              input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_is_mem = is_mem; req_addr = a; req_size = s;
        wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = 3'(sel); wr_data = d;
        sb_q.push_back(model(is_mem, a, s, tag));
        apply_model_write(idx, sel, d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0; wr_en = 1'b0;
        end
    endtask

    task automatic program_win(input int idx, input logic [31:0] f, input logic [63:0] pb,
                               input logic [63:0] ph, input logic [63:0] sz);
        wr(idx, 0, {32'd0, f});
        wr(idx, 1, pb);
        wr(idx, 2, ph);
        wr(idx, 3, sz);
        wr(idx, 4, 64'd1);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) req_seen <= rst ? 1'b0 : req_valid;

    // Monitor: results are due one cycle after each strobe.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid !== req_seen)
                check(1'b0, "R9 rsp_valid timing", 64'(rsp_valid), 64'(req_seen));
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", 64'(rsp_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_hit === e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
                    check(rsp_addr === e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
                    check(rsp_win === e.win, {e.tag, " win"}, 64'(rsp_win), 64'(e.win));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_flags[i] = '0; m_pci[i] = '0; m_phys[i] = '0; m_size[i] = '0; m_en[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1 reset flags",
              {62'd0, rsp_valid, rsp_hit}, 64'd0);
        check(rsp_addr === 64'd0, "R1 reset addr", rsp_addr, 64'd0);
        @(negedge clk); rst = 1'b0;

        // R1: fresh windows are disabled
        rq(1'b1, 64'h0, 64'h4, "R1 miss after reset");
        rq(1'b0, 64'h0, 64'h4, "R1 io miss after reset");
        idle(2);

        program_win(0, 32'h0100_0000, 64'h1000, 64'h8000_0000, 64'h1000);
        program_win(1, 32'h0200_0000, 64'h4000_0000, 64'h1_0000_0000, 64'h1000_0000);
        program_win(2, 32'h0300_0000, 64'h4000_0000, 64'h2_0000_0000, 64'h2000_0000);
        program_win(3, 32'h0300_0000, 64'hFFFF_FFFF_FFFF_F000, 64'h10_0000, 64'h1000);
        idle(1);

        rq(1'b0, 64'h1000, 64'h4, "R3 io hit");
        rq(1'b0, 64'h1FFC, 64'h4, "R5 io exact end");
        rq(1'b0, 64'h1FFD, 64'h4, "R5 io past end");
        rq(1'b0, 64'h0FFF, 64'h4, "R5 io below base");
        rq(1'b1, 64'h1000, 64'h4, "R4 mem vs io window");
        rq(1'b0, 64'h4000_0000, 64'h4, "R3 io vs mem window");
        idle(1);
        rq(1'b1, 64'h4000_0010, 64'h8, "R7 lowest index");
        rq(1'b1, 64'h5000_0000, 64'h4, "R4 prefetchable hit");
        rq(1'b1, 64'h4FFF_FFFE, 64'h4, "R5 straddle falls through");
        rq(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, "R6 top window translate");
        rq(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, "R5 wrap no hit");
        idle(2);

        // R10: disable window 1
        wr(1, 4, 64'd0);
        rq(1'b1, 64'h4000_0010, 64'h8, "R10 disabled skipped");
        // R2: unused select codes change nothing
        wr(2, 5, 64'hDEAD);
        wr(2, 7, 64'hBEEF);
        rq(1'b1, 64'h4000_0010, 64'h8, "R2 ignored select");
        // R11: write and request together
        rq_with_wr(1'b1, 64'h4000_0010, 64'h8, 1, 4, 64'd1, "R11 old contents");
        rq(1'b1, 64'h4000_0010, 64'h8, "R11 new contents");
        // R2: rebase window 0
        wr(0, 1, 64'h9000);
        rq(1'b0, 64'h9010, 64'h2, "R2 rebased io");
        rq(1'b0, 64'h1010, 64'h2, "R2 old base misses");
        idle(3);

        check(sb_q.size() == 0, "R9 all results seen", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule